// File: doc/BRIEF.md
# Configurable PLD Macrocell Register

This block is one output cell of a programmable logic array. It gathers two sums of product terms, optionally folds a single extra term into the first sum through an exclusive-OR, and turns the result into one output pin value. A static configuration word decides whether that value passes straight through or is stored first. It also decides which kind of storage cell is used, which clock drives the cell and on which edge, and whether the value is inverted on the way out.

The storage cell can act as a D flip-flop, a toggle flip-flop, a JK flip-flop, a set/clear flip-flop or a level-sensitive latch. Its clock is one of several shared global clocks, or a clock made by a product term inside the cell (asynchronous mode). In asynchronous mode, two further product terms give the cell its own set and clear. Each cell is configured on its own, so any mix of synchronous and asynchronous cells can sit side by side in an array.

Top module: `pld_macrocell`

## Requirements
- R1: With cfg bit 0 low (combinational), out_o equals sum A after the polarity stage, whatever the clocks do.
- R2: cfg bit 1 high inverts out_o. The inversion sits after the storage cell, so a stored 0 appears as 1.
- R3: With the type field cfg[4:2] = 0 (D; codes 5 to 7 also act as D), an active clock edge stores sum A.
- R4: With type 1 (toggle), an active edge inverts the stored bit when sum A is 1 and keeps it when sum A is 0.
- R5: With type 2 (JK; J = sum A, K = sum B), an active edge gives: 00 hold, 01 clear, 10 set, 11 toggle.
- R6: With type 3 (set/clear; S = sum A, R = sum B), an active edge gives: 10 set, 01 clear, and both 00 and the illegal 11 hold.
- R7: cfg bit 5 picks the active edge. With 0 the rising edge of the selected clock is active, and with 1 the falling edge.
- R8: cfg[8:7] picks which global clock is used. Edges on the other global clocks do not change the output.
- R9: cfg bit 6 high (asynchronous mode) clocks the cell from the aclk_pt_i product term in place of the global clocks, with the same edge choice.
- R10: rst_n low clears the stored bit to 0 and holds it there. grst_i clears and gset_i sets asynchronously, and a clear wins over a set.
- R11: Type 4 makes the cell a latch. It is transparent while the selected clock sits at its active level (high when cfg bit 5 is 0, low when it is 1) and holds otherwise.
- R12: In asynchronous mode, arst_pt_i clears and aset_pt_i sets the cell at once, with clear winning. With cfg bit 6 low, both are ignored.
- R13: Sum A is the OR of all pta_i terms, exclusive-ORed with ptx_i. Sum B is the OR of all ptb_i terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Power-up clear, active low, asynchronous |
| cfg_i | input | CFG_W (9) | Static configuration word: {clock select, async mode, edge, type[2:0], invert, registered} |
| gclk_i | input | NUM_GCLK (4) | Global clocks |
| pta_i | input | PT_N (20) | Product terms summed into sum A |
| ptb_i | input | PT_N (20) | Product terms summed into sum B |
| ptx_i | input | 1 | Single term exclusive-ORed with sum A |
| aclk_pt_i | input | 1 | Product-term clock used in asynchronous mode |
| aset_pt_i | input | 1 | Product-term set used in asynchronous mode |
| arst_pt_i | input | 1 | Product-term clear used in asynchronous mode |
| gset_i | input | 1 | Global asynchronous set |
| grst_i | input | 1 | Global asynchronous clear |
| out_o | output | 1 | Macrocell output after the polarity stage |

## Verification
Every storage type starts from a cleared cell and gets two clock pulses with the same inputs. This separates a cell that holds its value (D, or JK with J only) from one that toggles (toggle type, JK 11), and it shows that set/clear 11 keeps its state. Sampling halfway through a clock pulse separates rising-edge capture from falling-edge capture. Pulses on a clock that is not selected must leave the output unchanged. Latch runs raise and lower the data while the clock is at its active level and at its inactive level, in both level choices. Set and clear are raised together to show that clear wins, and the asynchronous terms are raised again with asynchronous mode off to show that they have no effect.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

   // Storage type codes held in the type field of the configuration word
   localparam logic [2:0] TY_D   = 3'd0;
   localparam logic [2:0] TY_T   = 3'd1;
   localparam logic [2:0] TY_JK  = 3'd2;
   localparam logic [2:0] TY_SR  = 3'd3;
   localparam logic [2:0] TY_LAT = 3'd4;

   // Configuration word field offsets
   localparam int CF_REG   = 0;
   localparam int CF_INV   = 1;
   localparam int CF_TYP   = 2;
   localparam int CF_EDGE  = 5;
   localparam int CF_ASYNC = 6;
   localparam int CF_SEL   = 7;
   localparam int CF_FIXED = 7;  // bits below the clock-select field

   // Next state of the edge-triggered cell for every storage type
   function automatic logic cell_next(input logic [2:0] typ, input logic q,
                                      input logic a, input logic b);
      logic n;
      case (typ)
         TY_T:    n = q ^ a;
         TY_JK:   case ({a, b})
                     2'b10:   n = 1'b1;
                     2'b01:   n = 1'b0;
                     2'b11:   n = ~q;
                     default: n = q;
                  endcase
         TY_SR:   case ({a, b})
                     2'b10:   n = 1'b1;
                     2'b01:   n = 1'b0;
                     default: n = q;
                  endcase
         default: n = a;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/mcell_sum.sv
module mcell_sum #(
   parameter int PT_N   = 20,
   parameter bit XOR_EN = 1'b1
) (
   input  logic [PT_N-1:0] pta_i,
   input  logic [PT_N-1:0] ptb_i,
   input  logic            ptx_i,
   output logic            suma_o,
   output logic            sumb_o
);

   logic or_a;

   assign or_a   = |pta_i;
   assign sumb_o = |ptb_i;

   generate
      if (XOR_EN) begin : g_xor
         assign suma_o = or_a ^ ptx_i;
      end else begin : g_plain
         logic unused_x;
         assign unused_x = ptx_i;
         assign suma_o   = or_a;
      end
   endgenerate

endmodule

// File: rtl/mcell_clksel.sv
module mcell_clksel #(
   parameter int NUM_GCLK = 4,
   parameter int SEL_W    = 2
) (
   input  logic [NUM_GCLK-1:0] gclk_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic                edge_i,
   input  logic                async_i,
   input  logic                aclk_i,
   output logic                clk_o
);

   logic picked;
   logic src;

   generate
      if (NUM_GCLK == (1 << SEL_W)) begin : g_full
         assign picked = gclk_i[sel_i];
      end else begin : g_partial
         // Codes past the last clock fall back to clock 0
         always_comb begin
            picked = gclk_i[0];
            for (int k = 1; k < NUM_GCLK; k++) begin
               if (sel_i == SEL_W'(k)) picked = gclk_i[k];
            end
         end
      end
   endgenerate

   assign src   = async_i ? aclk_i : picked;
   // Active edge becomes a rising edge, active level becomes high
   assign clk_o = src ^ edge_i;

endmodule

// File: rtl/mcell_store.sv
module mcell_store
   import mcell_pkg::*;
(
   input  logic       clk_i,
   input  logic       clr_i,
   input  logic       set_i,
   input  logic [2:0] typ_i,
   input  logic       a_i,
   input  logic       b_i,
   output logic       q_o
);

   logic fq_q;
   logic lq_q;
   logic live_q;
   logic nxt;

   assign nxt = cell_next(typ_i, fq_q, a_i, b_i);

   // Edge-triggered cell; live_q marks an edge taken with no set/clear since
   always_ff @(posedge clk_i or posedge clr_i or posedge set_i) begin
      if (clr_i) begin
         fq_q   <= 1'b0;
         live_q <= 1'b0;
      end else if (set_i) begin
         fq_q   <= 1'b1;
         live_q <= 1'b0;
      end else begin
         fq_q   <= nxt;
         live_q <= 1'b1;
      end
   end

   // Level-sensitive cell, transparent while the normalised clock is high
   always_latch begin
      if (clr_i)      lq_q = 1'b0;
      else if (set_i) lq_q = 1'b1;
      else if (clk_i) lq_q = a_i;
   end

   assign q_o = (typ_i == TY_LAT) ? lq_q : fq_q;

   a_r3_d_capture: assert property (@(posedge clk_i) disable iff (clr_i || set_i)
      (live_q && $past(typ_i) == TY_D) |-> fq_q == $past(a_i));

   a_r4_t_toggle: assert property (@(posedge clk_i) disable iff (clr_i || set_i)
      (live_q && $past(typ_i) == TY_T && $past(a_i)) |-> fq_q != $past(fq_q));

   a_r5_jk_toggle: assert property (@(posedge clk_i) disable iff (clr_i || set_i)
      (live_q && $past(typ_i) == TY_JK && $past(a_i && b_i)) |-> fq_q != $past(fq_q));

   a_r6_sr_hold: assert property (@(posedge clk_i) disable iff (clr_i || set_i)
      (live_q && $past(typ_i) == TY_SR && $past(a_i && b_i)) |-> fq_q == $past(fq_q));

   a_r11_latch_follow: assert property (@(negedge clk_i) disable iff (clr_i || set_i)
      (typ_i == TY_LAT) |-> lq_q == a_i);

   a_r10_clear_holds: assert property (@(posedge clk_i)
      clr_i |-> (fq_q == 1'b0 && lq_q == 1'b0));

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import mcell_pkg::*;
#(
   parameter int NUM_GCLK = 4,
   parameter int PT_N     = 20,
   parameter bit XOR_EN   = 1'b1,
   parameter int SEL_W    = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1,
   parameter int CFG_W    = CF_FIXED + SEL_W
) (
   input  logic                rst_n,
   input  logic [CFG_W-1:0]    cfg_i,
   input  logic [NUM_GCLK-1:0] gclk_i,
   input  logic [PT_N-1:0]     pta_i,
   input  logic [PT_N-1:0]     ptb_i,
   input  logic                ptx_i,
   input  logic                aclk_pt_i,
   input  logic                aset_pt_i,
   input  logic                arst_pt_i,
   input  logic                gset_i,
   input  logic                grst_i,
   output logic                out_o
);

   localparam int SEL_NEED = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1;

   generate
      if (NUM_GCLK < 2)               begin : g_bad_gclk $error("NUM_GCLK must be at least 2");        end
      if (PT_N < 1 || PT_N > 64)      begin : g_bad_pt   $error("PT_N must lie in 1..64");             end
      if (SEL_W != SEL_NEED)          begin : g_bad_sel  $error("SEL_W must match NUM_GCLK");          end
      if (CFG_W != CF_FIXED + SEL_W)  begin : g_bad_cfg  $error("CFG_W must equal CF_FIXED + SEL_W");  end
   endgenerate

   logic             c_reg;
   logic             c_inv;
   logic [2:0]       c_typ;
   logic             c_edge;
   logic             c_async;
   logic [SEL_W-1:0] c_sel;

   assign c_reg   = cfg_i[CF_REG];
   assign c_inv   = cfg_i[CF_INV];
   assign c_typ   = cfg_i[CF_TYP +: 3];
   assign c_edge  = cfg_i[CF_EDGE];
   assign c_async = cfg_i[CF_ASYNC];
   assign c_sel   = cfg_i[CF_SEL +: SEL_W];

   logic sum_a;
   logic sum_b;
   logic cell_clk;
   logic cell_clr;
   logic cell_set;
   logic cell_q;

   mcell_sum #(.PT_N(PT_N), .XOR_EN(XOR_EN)) u_sum (
      .pta_i  (pta_i),
      .ptb_i  (ptb_i),
      .ptx_i  (ptx_i),
      .suma_o (sum_a),
      .sumb_o (sum_b)
   );

   mcell_clksel #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_clk (
      .gclk_i  (gclk_i),
      .sel_i   (c_sel),
      .edge_i  (c_edge),
      .async_i (c_async),
      .aclk_i  (aclk_pt_i),
      .clk_o   (cell_clk)
   );

   // Clear dominates set; the product-term controls count only in async mode
   assign cell_clr = ~rst_n | grst_i | (c_async & arst_pt_i);
   assign cell_set = gset_i | (c_async & aset_pt_i);

   mcell_store u_store (
      .clk_i (cell_clk),
      .clr_i (cell_clr),
      .set_i (cell_set),
      .typ_i (c_typ),
      .a_i   (sum_a),
      .b_i   (sum_b),
      .q_o   (cell_q)
   );

   assign out_o = (c_reg ? cell_q : sum_a) ^ c_inv;

   a_r12_clear_wins: assert property (@(posedge cell_clk)
      (cell_clr && c_reg) |-> out_o == c_inv);

endmodule

// File: tb/pld_macrocell_tb.sv
module pld_macrocell_tb;

   localparam int NG  = 4;
   localparam int PTN = 20;
   localparam int NV  = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [8:0]      cfg;
   logic [NG-1:0]   gclk;
   logic [PTN-1:0]  pta, ptb;
   logic            ptx, aclk, aset, arst, gset, grst;
   logic            out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pld_macrocell u_dut (
      .rst_n     (rst_n),
      .cfg_i     (cfg),
      .gclk_i    (gclk),
      .pta_i     (pta),
      .ptb_i     (ptb),
      .ptx_i     (ptx),
      .aclk_pt_i (aclk),
      .aset_pt_i (aset),
      .arst_pt_i (arst),
      .gset_i    (gset),
      .grst_i    (grst),
      .out_o     (out)
   );

   // cfg layout: {sel[1:0], async, edge, type[2:0], invert, registered}
   function automatic logic [8:0] mk(input logic rg, input logic inv, input logic [2:0] ty,
                                     input logic edg, input logic asy, input logic [1:0] sel);
      return {sel, asy, edg, ty, inv, rg};
   endfunction

   // Vector: {cfg[8:0], a, b, expect after pulse 1, expect after pulse 2, requirement[3:0]}
   localparam logic [16:0] VT [0:NV-1] = '{
      {mk(0,0,3'd0,0,0,2'd0), 1'b1,1'b0, 1'b1,1'b1, 4'd1},  // R1 pass-through
      {mk(0,1,3'd0,0,0,2'd0), 1'b1,1'b0, 1'b0,1'b0, 4'd2},  // R2 inverted pass-through
      {mk(1,0,3'd0,0,0,2'd0), 1'b1,1'b0, 1'b1,1'b1, 4'd3},  // R3 D stores 1
      {mk(1,0,3'd0,0,0,2'd0), 1'b0,1'b0, 1'b0,1'b0, 4'd3},  // R3 D stores 0
      {mk(1,1,3'd0,0,0,2'd0), 1'b1,1'b0, 1'b0,1'b0, 4'd2},  // R2 inversion after register
      {mk(1,0,3'd1,0,0,2'd0), 1'b1,1'b0, 1'b1,1'b0, 4'd4},  // R4 toggle
      {mk(1,0,3'd1,0,0,2'd0), 1'b0,1'b0, 1'b0,1'b0, 4'd4},  // R4 toggle held
      {mk(1,0,3'd2,0,0,2'd0), 1'b1,1'b0, 1'b1,1'b1, 4'd5},  // R5 JK set
      {mk(1,0,3'd2,0,0,2'd0), 1'b1,1'b1, 1'b1,1'b0, 4'd5},  // R5 JK toggle
      {mk(1,0,3'd2,0,0,2'd0), 1'b0,1'b1, 1'b0,1'b0, 4'd5},  // R5 JK clear
      {mk(1,0,3'd3,0,0,2'd0), 1'b1,1'b0, 1'b1,1'b1, 4'd6},  // R6 SR set
      {mk(1,0,3'd3,0,0,2'd0), 1'b1,1'b1, 1'b0,1'b0, 4'd6},  // R6 SR illegal holds
      {mk(1,0,3'd3,0,0,2'd0), 1'b0,1'b1, 1'b0,1'b0, 4'd6},  // R6 SR clear
      {mk(1,0,3'd0,0,0,2'd2), 1'b1,1'b0, 1'b1,1'b1, 4'd8},  // R8 global clock 2
      {mk(1,0,3'd0,1,0,2'd3), 1'b1,1'b0, 1'b1,1'b1, 4'd7},  // R7 falling edge, clock 3
      {mk(1,0,3'd1,0,1,2'd0), 1'b1,1'b0, 1'b1,1'b0, 4'd9}   // R9 async toggle
   };

   task automatic chk(input int req, input logic exp, input string what);
      @(negedge clk);
      checks++;
      if (out !== exp) begin
         errors++;
         $display("FAIL R%0d %s: out=%b expected=%b", req, what, out, exp);
      end
   endtask

   task automatic setup(input logic [8:0] c);
      @(negedge clk);
      rst_n = 1'b0;
      pta = '0; ptb = '0; ptx = 1'b0;
      aset = 1'b0; arst = 1'b0; gset = 1'b0; grst = 1'b0;
      @(negedge clk);
      cfg = c;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse(input logic asy, input int sel);
      @(negedge clk);
      if (asy) aclk = 1'b1; else gclk[sel] = 1'b1;
      @(negedge clk);
      if (asy) aclk = 1'b0; else gclk[sel] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg = '0; gclk = '0; pta = '0; ptb = '0; ptx = 1'b0;
      aclk = 1'b0; aset = 1'b0; arst = 1'b0; gset = 1'b0; grst = 1'b0;
      repeat (3) @(negedge clk);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         logic [16:0] v;
         v = VT[i];
         setup(v[16:8]);
         pta = v[7] ? 20'h00010 : '0;
         ptb = v[6] ? 20'h80000 : '0;
         pulse(v[14], int'(v[16:15]));
         chk(int'(v[3:0]), v[5], $sformatf("vector %0d pulse 1", i));
         pulse(v[14], int'(v[16:15]));
         chk(int'(v[3:0]), v[4], $sformatf("vector %0d pulse 2", i));
      end

      // R10 reset state, inversion after the cleared register, clocks ignored in reset
      setup(mk(1,0,3'd0,0,0,2'd0));
      chk(10, 1'b0, "cleared after reset");
      setup(mk(1,1,3'd0,0,0,2'd0));
      chk(10, 1'b1, "cleared cell seen through inversion");
      @(negedge clk); rst_n = 1'b0; pta = 20'h1;
      pulse(1'b0, 0);
      chk(10, 1'b1, "edge during reset ignored");
      rst_n = 1'b1;

      // R10 global set / clear, clear wins
      setup(mk(1,0,3'd0,0,0,2'd0));
      gset = 1'b1;
      chk(10, 1'b1, "global set");
      grst = 1'b1;
      chk(10, 1'b0, "global clear over set");
      grst = 1'b0; gset = 1'b0;
      chk(10, 1'b0, "released after global clear");

      // R7 rising edge captures mid-pulse; falling edge waits for the fall
      setup(mk(1,0,3'd0,0,0,2'd0));
      pta = 20'h2;
      @(negedge clk); gclk[0] = 1'b1;
      chk(7, 1'b1, "rising edge captured before fall");
      gclk[0] = 1'b0;
      setup(mk(1,0,3'd0,1,0,2'd0));
      pta = 20'h2;
      @(negedge clk); gclk[0] = 1'b1;
      chk(7, 1'b0, "falling-edge cell ignores rise");
      gclk[0] = 1'b0;
      chk(7, 1'b1, "falling-edge cell captures on fall");

      // R8 unselected clock ignored
      setup(mk(1,0,3'd0,0,0,2'd1));
      pta = 20'h4;
      pulse(1'b0, 0);
      chk(8, 1'b0, "clock 0 ignored when clock 1 selected");
      pulse(1'b1, 0);
      chk(8, 1'b0, "product-term clock ignored in sync mode");
      pulse(1'b0, 1);
      chk(8, 1'b1, "clock 1 captures");

      // R11 latch, transparent high
      setup(mk(1,0,3'd4,0,0,2'd0));
      pta = 20'h8;
      chk(11, 1'b0, "latch closed while clock low");
      gclk[0] = 1'b1;
      chk(11, 1'b1, "latch opens");
      pta = '0;
      chk(11, 1'b0, "latch follows while open");
      gclk[0] = 1'b0;
      @(negedge clk); pta = 20'h8;
      chk(11, 1'b0, "latch holds after close");

      // R11 latch, transparent low
      setup(mk(1,0,3'd4,1,0,2'd0));
      pta = 20'h8;
      chk(11, 1'b1, "low-level latch open with clock low");
      gclk[0] = 1'b1;
      @(negedge clk); pta = '0;
      chk(11, 1'b1, "low-level latch holds with clock high");
      gclk[0] = 1'b0;
      chk(11, 1'b0, "low-level latch reopens");

      // R12 product-term set / clear in async mode
      setup(mk(1,0,3'd0,0,1,2'd0));
      aset = 1'b1;
      chk(12, 1'b1, "async set");
      arst = 1'b1;
      chk(12, 1'b0, "async clear over set");
      arst = 1'b0; aset = 1'b0;
      chk(12, 1'b0, "stays clear after release");
      aset = 1'b1;
      @(negedge clk); aset = 1'b0;
      chk(12, 1'b1, "set persists after release");
      setup(mk(1,0,3'd0,0,0,2'd0));
      aset = 1'b1;
      chk(12, 1'b0, "product-term set ignored in sync mode");
      aset = 1'b0;
      setup(mk(1,1,3'd0,0,0,2'd0));
      pulse(1'b0, 0);
      pta = 20'h1;
      pulse(1'b0, 0);
      arst = 1'b1;
      chk(12, 1'b0, "product-term clear ignored in sync mode");
      arst = 1'b0;

      // R13 product-term sums and the XOR term
      setup(mk(0,0,3'd0,0,0,2'd0));
      ptx = 1'b1;
      chk(13, 1'b1, "XOR term alone");
      pta = 20'h00005;
      chk(13, 1'b0, "XOR term cancels sum");
      ptx = 1'b0; pta = 20'h80000;
      chk(13, 1'b1, "top product term");
      setup(mk(1,0,3'd3,0,0,2'd0));
      pta = 20'h1;
      pulse(1'b0, 0);
      pta = '0; ptb = 20'h00400;
      pulse(1'b0, 0);
      chk(13, 1'b0, "sum B from a middle term clears SR cell");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule